// File: doc/BRIEF.md
# Swap-Access Countdown Timer

This block is a cycle countdown timer whose only programming path is a swap: a single load strobe writes a new count and, in the same cycle, the old-count output carries the count that the load is about to replace. Software that moves a timer value in and out in one operation can therefore save and reprogram the timer without losing cycles between a read and a write.

While the count is non-zero it drops by one on every clock. When a decrement takes it from one to zero, the block sends a single-cycle interrupt request to the interrupt controller. A count of zero means the timer is stopped: it stays at zero and raises nothing. A load flagged as coming from the hard-wired zero source register stores zero, whatever the data value, and so stops the timer.

Top module: `swap_countdown_timer`

## Requirements
- R1: While no load is applied and the count is non-zero, the count decreases by exactly one on each rising clock edge.
- R2: `irqPulse` goes high only in the cycle right after a decrement took the count from 1 to 0.
- R3: With no load and a count of zero, the count stays at zero and `irqPulse` stays low.
- R4: When `loadEn` is high, `oldCount` shows the count held before that edge, and after the edge the count equals `loadValue`.
- R5: A load with `loadFromZero` high stores zero regardless of `loadValue`, which stops the timer.
- R6: A load overrides a decrement in the same cycle. `oldCount` then shows the count before the decrement, and a load arriving while the count is 1 raises no interrupt.
- R7: `irqPulse` is high for exactly one cycle for each expiry.
- R8: Loading the value 1 makes `irqPulse` high in the cycle after the next edge, which is the cycle where the count first reads 0.
- R9: After reset the count is zero and `irqPulse` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low synchronous reset |
| loadEn | input | 1 | Swap strobe: loads a new count on this edge |
| loadFromZero | input | 1 | The load comes from the zero source register, so zero is stored |
| loadValue | input | WIDTH (32) | New count to store |
| oldCount | output | WIDTH (32) | Current count; during a load, the value being replaced |
| irqPulse | output | 1 | One-cycle interrupt request on expiry |

## Verification
A load and a decrement can fall in the same cycle, and so can a load and an expiry. The bench provokes both by asserting `loadEn` while the count is 1 and while it is some other non-zero value. A behavioural model, updated on every clock, computes the expected count and interrupt. Each cycle the bench compares the design against that model, so it judges whether the load wins, whether `oldCount` shows the pre-decrement value, and whether the expiry interrupt is suppressed.

// File: rtl/countdown_pkg.sv
package countdown_pkg;

  // Strobes from control to datapath for one cycle
  typedef struct packed {
    logic loadNow;    // replace the count
    logic zeroSrc;    // the replacement is forced to zero
    logic decNow;     // decrement the count
    logic expireNow;  // this decrement reaches zero
  } tmrCtl_t;

endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import countdown_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    loadEn,
  input  logic    loadFromZero,
  input  logic    cntIsZero,
  input  logic    cntIsOne,
  output tmrCtl_t ctl,
  output logic    irqPulse
);

  logic irqQ;

  always_comb begin
    ctl.loadNow   = loadEn;
    ctl.zeroSrc   = loadEn & loadFromZero;
    ctl.decNow    = ~loadEn & ~cntIsZero;
    ctl.expireNow = ~loadEn & cntIsOne;
  end

  always_ff @(posedge clk) begin
    if (!rstN) irqQ <= 1'b0;
    else       irqQ <= ctl.expireNow;
  end

  assign irqPulse = irqQ;

  AST_IRQ_FROM_EXPIRY: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |-> ($past(cntIsOne) && !$past(loadEn))); // R2

  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |=> !irqPulse); // R7

  AST_IDLE_NO_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    (cntIsZero && !loadEn) |=> !irqPulse); // R3

endmodule

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import countdown_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  tmrCtl_t          ctl,
  input  logic [WIDTH-1:0] loadValue,
  output logic [WIDTH-1:0] count,
  output logic             cntIsZero,
  output logic             cntIsOne
);

  localparam logic [WIDTH-1:0] ZERO = '0;
  localparam logic [WIDTH-1:0] ONE  = {{(WIDTH-1){1'b0}}, 1'b1};

  logic [WIDTH-1:0] countQ;
  logic [WIDTH-1:0] countNext;

  always_comb begin
    countNext = countQ;
    if (ctl.loadNow)     countNext = ctl.zeroSrc ? ZERO : loadValue;
    else if (ctl.decNow) countNext = countQ - ONE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) countQ <= ZERO;
    else       countQ <= countNext;
  end

  assign count     = countQ;
  assign cntIsZero = (countQ == ZERO);
  assign cntIsOne  = (countQ == ONE);

  AST_DEC_BY_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.loadNow && countQ != ZERO) |=> countQ == $past(countQ) - ONE); // R1

  AST_ZERO_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.loadNow && countQ == ZERO) |=> countQ == ZERO); // R3

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.loadNow && !ctl.zeroSrc) |=> countQ == $past(loadValue)); // R6

  AST_ZERO_SRC: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.loadNow && ctl.zeroSrc) |=> countQ == ZERO); // R5

endmodule

// File: rtl/swap_countdown_timer.sv
module swap_countdown_timer
  import countdown_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             loadEn,
  input  logic             loadFromZero,
  input  logic [WIDTH-1:0] loadValue,
  output logic [WIDTH-1:0] oldCount,
  output logic             irqPulse
);

  tmrCtl_t          ctl;
  logic [WIDTH-1:0] count;
  logic             cntIsZero;
  logic             cntIsOne;

  tmr_ctrl ctrl_i (
    .clk          (clk),
    .rstN         (rstN),
    .loadEn       (loadEn),
    .loadFromZero (loadFromZero),
    .cntIsZero    (cntIsZero),
    .cntIsOne     (cntIsOne),
    .ctl          (ctl),
    .irqPulse     (irqPulse)
  );

  tmr_datapath #(.WIDTH(WIDTH)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .loadValue (loadValue),
    .count     (count),
    .cntIsZero (cntIsZero),
    .cntIsOne  (cntIsOne)
  );

  // The swap output: during a load this is the value being replaced
  assign oldCount = count;

endmodule

// File: tb/swap_countdown_timer_tb.sv
module swap_countdown_timer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG = 5000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        loadEn = 1'b0;
  logic        loadFromZero = 1'b0;
  logic [31:0] loadValue = '0;
  logic [31:0] oldCount;
  logic        irqPulse;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 1'b0;

  logic [31:0] mCount = '0;
  logic        mIrq = 1'b0;

  swap_countdown_timer #(.WIDTH(32)) dut_i (
    .clk(clk), .rstN(rstN), .loadEn(loadEn), .loadFromZero(loadFromZero),
    .loadValue(loadValue), .oldCount(oldCount), .irqPulse(irqPulse)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      done = 1'b1;
      checks++; failures++;
      $display("FAIL watchdog expired after %0d cycles (expected completion)", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic compare(input string tag);
    checks++;
    if (oldCount !== mCount) begin
      failures++;
      $display("FAIL %s oldCount actual=%0d expected=%0d", tag, oldCount, mCount);
    end
    checks++;
    if (irqPulse !== mIrq) begin
      failures++;
      $display("FAIL %s irqPulse actual=%0b expected=%0b", tag, irqPulse, mIrq);
    end
  endtask

  // Drive inputs at the falling edge, check, then advance the model at the rising edge
  task automatic step(input bit ld, input bit z, input logic [31:0] v, input string tag);
    @(negedge clk);
    loadEn = ld; loadFromZero = z; loadValue = v;
    #1;
    compare(tag);
    @(posedge clk);
    if (ld) begin
      mCount = z ? 32'd0 : v;
      mIrq = 1'b0;
    end else if (mCount != 0) begin
      mIrq = (mCount == 32'd1);
      mCount = mCount - 32'd1;
    end else begin
      mIrq = 1'b0;
    end
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 32'hDEAD_BEEF, tag);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    // R9: reset state, then R3 idle at zero
    #1 compare("R9");
    idle(4, "R3");
    // R4 load, R1 countdown, R2/R7 expiry pulse
    step(1'b1, 1'b0, 32'd6, "R4");
    idle(9, "R1_R2_R7");
    // R8 load of one
    step(1'b1, 1'b0, 32'd1, "R8");
    idle(3, "R8");
    // R6 load while count is 1: load wins, no interrupt
    step(1'b1, 1'b0, 32'd2, "R6");
    step(1'b0, 1'b0, 32'd0, "R6");
    step(1'b1, 1'b0, 32'd5, "R6");
    idle(2, "R6");
    // R6 swap mid-count: old value before the decrement
    step(1'b1, 1'b0, 32'hFFFF_FFFF, "R6");
    idle(3, "R1");
    // R5 zero-source load stops the timer despite a non-zero data value
    step(1'b1, 1'b1, 32'd77, "R5");
    idle(4, "R5");
    // R5 zero-source load while count is 1 suppresses the interrupt
    step(1'b1, 1'b0, 32'd1, "R5");
    step(1'b1, 1'b1, 32'd9, "R5");
    idle(3, "R5");
    // R4 back-to-back swaps
    step(1'b1, 1'b0, 32'd40, "R4");
    step(1'b1, 1'b0, 32'd3, "R4");
    idle(6, "R2_R7");
    // R9 reset in mid-count
    step(1'b1, 1'b0, 32'd50, "R9");
    idle(2, "R9");
    @(negedge clk); rstN = 1'b0; loadEn = 1'b0;
    @(posedge clk); mCount = '0; mIrq = 1'b0;
    @(negedge clk); rstN = 1'b1;
    #1 compare("R9");
    idle(3, "R3");
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule